// File: doc/BRIEF.md
# Transmit FIFO with Sync Fill

This block is the character-supply stage of a byte-synchronous serial transmitter. A processor writes characters into a three-entry queue through a small register port. Just before each new character begins, the bit shifter raises a load request. The block answers on the next cycle with the character to send. When the queue has run dry, it either substitutes the programmed sync character or sends an idle pattern of all ones. Substituting the sync character marks an underflow event on both a sticky status bit and a one-cycle output pulse.

The block keeps a "room available" flag for the processor. The flag uses a threshold that the processor selects: one free entry or two. It is updated with hysteresis: a data write can only clear it, and a pop by the shifter can only set it. A transmitter-reset control bit holds the shifter side idle, flushes the queue and clears the sticky status. While reset is held, the visible room flag reads as zero, but the internal flag keeps following the queue. The block also holds the clear-to-send status bit. Another unit sets it through a pulse input, and the processor clears it here.

Top module: `sync_tx_fill`

## Requirements
- R1: After `rst_n` is asserted, the transmitter-reset bit is 1, the queue is empty, both mode bits and the sync code are 0, `ld_data` is 0xFF, and `ld_underflow`, `sts_avail`, `sts_underflow` and `sts_cts` are 0.
- R2: The queue holds 3 characters in write order. A data write (address 4) made while all 3 entries are occupied is dropped.
- R3: After a data write, the internal room flag clears if the free-entry count is below the trigger. The trigger is 1 when mode bit 0 (address 1) is set and 2 when it is clear.
- R4: After a pop by the shifter, the internal room flag sets if the free-entry count is at least the trigger.
- R5: While the transmitter-reset bit (bit 0 at address 0) is 1, a load request returns 0xFF and does not pop the queue. Data writes are still accepted.
- R6: A load request on an empty queue with mode bit 1 set returns the sync code (address 3) and sets `sts_underflow`. It also raises `ld_underflow` for exactly one cycle.
- R7: A load request on an empty queue with mode bit 1 clear returns 0xFF. `ld_underflow` stays low and `sts_underflow` is unchanged.
- R8: Each write of address 0 with bit 0 set empties the queue, clears `sts_underflow` and `sts_cts`, and sets the internal room flag. This includes a write made while reset is already held.
- R9: `sts_avail` shows the internal room flag while the transmitter-reset bit is 0 and reads 0 while it is 1.
- R10: A write to address 2 clears `sts_underflow` with bit 0 and `sts_cts` with bit 1. A pulse on `cts_event` sets `sts_cts`. When a set and a clear fall in the same cycle, the set wins.
- R11: A data write and a pop in the same cycle both take effect. The pop returns the old head, and the new character joins the tail. On an empty queue, the load is treated as an underflow and the written character is kept.
- R12: `ld_data` and `ld_underflow` change on the clock edge that samples `ld_req`. `ld_data` holds its value until the next load request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0 control, 1 mode, 2 clear, 3 sync code, 4 data |
| wr_data | input | 8 | Register write value |
| cts_event | input | 1 | Pulse that sets the clear-to-send status bit |
| ld_req | input | 1 | Shifter request for the next character |
| ld_data | output | 8 | Character handed to the shifter |
| ld_underflow | output | 1 | One-cycle pulse when a load was served by the sync code |
| sts_avail | output | 1 | Room-available status, masked during transmitter reset |
| sts_underflow | output | 1 | Sticky underflow status |
| sts_cts | output | 1 | Sticky clear-to-send status |

## Verification
The processor push and the shifter pop can land on the same clock edge. The bench provokes this by raising a data write and `ld_req` in one cycle, once with one character queued and once with the queue empty and sync fill enabled. It judges the result by the character returned, the room flag that follows, and the next load, which must return the newly written character in order. A related collision, a status clear in the same cycle as an underflowing load, is also driven. It must leave `sts_underflow` set.

// File: rtl/tx_fill_pkg.sv
package tx_fill_pkg;

  localparam int DATA_W     = 8;
  localparam int FIFO_DEPTH = 3;
  localparam int ADDR_W     = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL  = 3'd0,
    SEL_MODE  = 3'd1,
    SEL_CLEAR = 3'd2,
    SEL_SYNC  = 3'd3,
    SEL_DATA  = 3'd4
  } reg_sel_e;

  // bit positions inside the register values
  localparam int CTRL_RST_BIT  = 0;
  localparam int MODE_ONE_BIT  = 0;
  localparam int MODE_SYNC_BIT = 1;
  localparam int CLR_TUF_BIT   = 0;
  localparam int CLR_CTS_BIT   = 1;

  localparam int TRIG_LOW  = 1;
  localparam int TRIG_HIGH = 2;

endpackage

// File: rtl/tx_fill_fifo.sv
module tx_fill_fifo
  import tx_fill_pkg::*;
#(
  parameter int W     = DATA_W,
  parameter int DEPTH = FIFO_DEPTH,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count
);

  logic [DEPTH-1:0][W-1:0] mem_q;
  logic [PTR_W-1:0]        wr_ptr_q, wr_ptr_n;
  logic [PTR_W-1:0]        rd_ptr_q, rd_ptr_n;
  logic [CNT_W-1:0]        cnt_q, cnt_n;
  logic [DEPTH-1:0]        slot_we;
  logic                    full, acc, do_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (cnt_q == CNT_W'(DEPTH));
  assign acc    = push && !full && !flush;
  assign do_pop = pop && (cnt_q != '0) && !flush;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot_we
      assign slot_we[g] = acc && (wr_ptr_q == PTR_W'(g));
    end
  endgenerate

  always_comb begin
    wr_ptr_n = wr_ptr_q;
    rd_ptr_n = rd_ptr_q;
    cnt_n    = cnt_q;
    if (flush) begin
      wr_ptr_n = '0;
      rd_ptr_n = '0;
      cnt_n    = '0;
    end else begin
      if (acc)    wr_ptr_n = ptr_inc(wr_ptr_q);
      if (do_pop) rd_ptr_n = ptr_inc(rd_ptr_q);
      cnt_n = cnt_q + CNT_W'(acc) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_n;
      rd_ptr_q <= rd_ptr_n;
      cnt_q    <= cnt_n;
    end
  end

  // data path storage, no reset needed
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_we[i]) mem_q[i] <= din;
    end
  end

  assign head  = mem_q[rd_ptr_q];
  assign count = cnt_q;

  // R2: a write into a full queue leaves it full and unchanged in size
  p_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (count == CNT_W'(DEPTH)));

  // R7: the requester never pops an empty queue
  p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));

endmodule

// File: rtl/tx_fill_regs.sv
module tx_fill_regs
  import tx_fill_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic              xrst,
  output logic              one_byte,
  output logic              tx_sync,
  output logic [W-1:0]      sync_code,
  output logic              flush,
  output logic              push,
  output logic              clr_tuf,
  output logic              clr_cts
);

  logic         xrst_q, xrst_n;
  logic [1:0]   mode_q, mode_n;
  logic [W-1:0] sync_q, sync_n;
  logic         hit_ctrl, hit_mode, hit_clear, hit_sync, hit_data;

  assign hit_ctrl  = wr_en && (wr_addr == SEL_CTRL);
  assign hit_mode  = wr_en && (wr_addr == SEL_MODE);
  assign hit_clear = wr_en && (wr_addr == SEL_CLEAR);
  assign hit_sync  = wr_en && (wr_addr == SEL_SYNC);
  assign hit_data  = wr_en && (wr_addr == SEL_DATA);

  always_comb begin
    xrst_n = xrst_q;
    mode_n = mode_q;
    sync_n = sync_q;
    if (hit_ctrl) xrst_n = wr_data[CTRL_RST_BIT];
    if (hit_mode) mode_n = {wr_data[MODE_SYNC_BIT], wr_data[MODE_ONE_BIT]};
    if (hit_sync) sync_n = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xrst_q <= 1'b1;
      mode_q <= '0;
      sync_q <= '0;
    end else begin
      xrst_q <= xrst_n;
      mode_q <= mode_n;
      sync_q <= sync_n;
    end
  end

  assign xrst      = xrst_q;
  assign one_byte  = mode_q[0];
  assign tx_sync   = mode_q[1];
  assign sync_code = sync_q;
  assign flush     = hit_ctrl && wr_data[CTRL_RST_BIT];
  assign push      = hit_data;
  assign clr_tuf   = hit_clear && wr_data[CLR_TUF_BIT];
  assign clr_cts   = hit_clear && wr_data[CLR_CTS_BIT];

  // R8: a flushing control write leaves the transmitter held in reset
  p_flush_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> xrst);

endmodule

// File: rtl/tx_fill_status.sv
module tx_fill_status
  import tx_fill_pkg::*;
#(
  parameter int DEPTH = FIFO_DEPTH,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [CNT_W-1:0] count,
  input  logic             one_byte,
  input  logic             set_tuf,
  input  logic             clr_tuf,
  input  logic             set_cts,
  input  logic             clr_cts,
  output logic             avail,
  output logic             tuf,
  output logic             cts
);

  logic             avail_q, avail_n;
  logic             tuf_q, tuf_n;
  logic             cts_q, cts_n;
  logic             acc;
  logic [CNT_W-1:0] cnt_after, free_after, trig;

  assign acc        = push && (count != CNT_W'(DEPTH));
  assign cnt_after  = count + CNT_W'(acc) - CNT_W'(pop);
  assign free_after = CNT_W'(DEPTH) - cnt_after;
  assign trig       = one_byte ? CNT_W'(TRIG_LOW) : CNT_W'(TRIG_HIGH);

  always_comb begin
    avail_n = avail_q;
    tuf_n   = tuf_q;
    cts_n   = cts_q;
    if (flush) begin
      avail_n = 1'b1;
      tuf_n   = 1'b0;
      cts_n   = 1'b0;
    end else begin
      if (push && (free_after < trig))  avail_n = 1'b0;
      if (pop  && (free_after >= trig)) avail_n = 1'b1;
      if (clr_tuf) tuf_n = 1'b0;
      if (set_tuf) tuf_n = 1'b1;
      if (clr_cts) cts_n = 1'b0;
      if (set_cts) cts_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avail_q <= 1'b1;
      tuf_q   <= 1'b0;
      cts_q   <= 1'b0;
    end else begin
      avail_q <= avail_n;
      tuf_q   <= tuf_n;
      cts_q   <= cts_n;
    end
  end

  assign avail = avail_q;
  assign tuf   = tuf_q;
  assign cts   = cts_q;

  // R8: transmitter reset leaves the flags in their clean state
  p_flush_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (avail && !tuf && !cts));

  // R4: a pop that leaves enough room raises the flag
  p_avail_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !flush && (CNT_W'(DEPTH) - count + 1'b1 >= trig)) |=> avail);

  // R3: a write that leaves too little room drops the flag
  p_avail_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !flush && (count != '0) &&
     (CNT_W'(DEPTH) - count < trig + 1'b1)) |=> !avail);

  // R10: a set in the same cycle as a clear wins
  p_cts_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_cts && !flush) |=> cts);

endmodule

// File: rtl/sync_tx_fill.sv
module sync_tx_fill
  import tx_fill_pkg::*;
#(
  parameter int W     = DATA_W,
  parameter int DEPTH = FIFO_DEPTH,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic              cts_event,
  input  logic              ld_req,
  output logic [W-1:0]      ld_data,
  output logic              ld_underflow,
  output logic              sts_avail,
  output logic              sts_underflow,
  output logic              sts_cts
);

  logic             xrst, one_byte, tx_sync, flush, push, clr_tuf, clr_cts;
  logic [W-1:0]     sync_code, head;
  logic [CNT_W-1:0] count;
  logic             avail, pop, ufl_hit;
  logic [W-1:0]     ld_q, ld_n;
  logic             ufl_q, ufl_n;

  tx_fill_regs #(.W(W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .xrst      (xrst),
    .one_byte  (one_byte),
    .tx_sync   (tx_sync),
    .sync_code (sync_code),
    .flush     (flush),
    .push      (push),
    .clr_tuf   (clr_tuf),
    .clr_cts   (clr_cts)
  );

  tx_fill_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (push),
    .pop   (pop),
    .din   (wr_data),
    .head  (head),
    .count (count)
  );

  tx_fill_status #(.DEPTH(DEPTH)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .push     (push),
    .pop      (pop),
    .count    (count),
    .one_byte (one_byte),
    .set_tuf  (ufl_hit),
    .clr_tuf  (clr_tuf),
    .set_cts  (cts_event),
    .clr_cts  (clr_cts),
    .avail    (avail),
    .tuf      (sts_underflow),
    .cts      (sts_cts)
  );

  assign pop     = ld_req && !xrst && (count != '0);
  assign ufl_hit = ld_req && !xrst && (count == '0) && tx_sync;

  always_comb begin
    ld_n  = ld_q;
    ufl_n = ufl_hit && !flush;
    if (ld_req) begin
      if (xrst)                ld_n = '1;
      else if (count != '0)    ld_n = head;
      else if (tx_sync)        ld_n = sync_code;
      else                     ld_n = '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q  <= '1;
      ufl_q <= 1'b0;
    end else begin
      ld_q  <= ld_n;
      ufl_q <= ufl_n;
    end
  end

  assign ld_data      = ld_q;
  assign ld_underflow = ufl_q;
  assign sts_avail    = avail && !xrst;

  // R5: a load while held in reset returns the idle fill without a pulse
  p_hold_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && xrst) |=> ((ld_data == '1) && !ld_underflow));

  // R6: every underflow pulse is mirrored by the sticky status bit
  p_ufl_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_underflow |-> sts_underflow);

  // R7: with sync fill off no pulse ever appears
  p_no_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && !tx_sync) |=> !ld_underflow);

  // R12: without a request the character handed out holds
  p_ld_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_req |=> $stable(ld_data));

endmodule

// File: tb/sim_sync_tx_fill.sv
`timescale 1ns/1ps
module sim_sync_tx_fill;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       cts_event = 1'b0;
  logic       ld_req = 1'b0;
  logic [7:0] ld_data;
  logic       ld_underflow, sts_avail, sts_underflow, sts_cts;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sync_tx_fill u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cts_event(cts_event), .ld_req(ld_req),
    .ld_data(ld_data), .ld_underflow(ld_underflow), .sts_avail(sts_avail),
    .sts_underflow(sts_underflow), .sts_cts(sts_cts)
  );

  // vector: {is_load, addr, data, exp_ld, exp_ufl, exp_avail, exp_tuf}
  localparam int NV = 22;
  function automatic logic [22:0] vw(input logic [2:0] a, input logic [7:0] d,
                                     input logic av, input logic tf);
    return {1'b0, a, d, 8'h00, 1'b0, av, tf};
  endfunction
  function automatic logic [22:0] vl(input logic [7:0] e, input logic u,
                                     input logic av, input logic tf);
    return {1'b1, 3'd0, 8'h00, e, u, av, tf};
  endfunction

  localparam logic [22:0] VEC [NV] = '{
    vw(3'd0, 8'h00, 1, 0),  // release reset
    vw(3'd3, 8'h7E, 1, 0),  // sync code
    vl(8'hFF, 0, 1, 0),     // R7 empty, fill off
    vw(3'd1, 8'h02, 1, 0),  // sync fill on, trigger 2
    vl(8'h7E, 1, 1, 1),     // R6 underflow
    vw(3'd4, 8'hA1, 1, 1),  // R3 free 2
    vw(3'd4, 8'hB2, 0, 1),  // R3 free 1 < 2
    vw(3'd4, 8'hC3, 0, 1),
    vw(3'd4, 8'hD4, 0, 1),  // R2 dropped
    vl(8'hA1, 0, 0, 1),     // R4 free 1, stays low
    vl(8'hB2, 0, 1, 1),     // R4 free 2
    vl(8'hC3, 0, 1, 1),     // R2 D4 never queued
    vl(8'h7E, 1, 1, 1),
    vw(3'd2, 8'h01, 1, 0),  // R10 clear underflow
    vw(3'd1, 8'h03, 1, 0),  // trigger 1
    vw(3'd4, 8'h11, 1, 0),
    vw(3'd4, 8'h22, 1, 0),
    vw(3'd4, 8'h33, 0, 0),  // R3 free 0 < 1
    vl(8'h11, 0, 1, 0),     // R4 free 1 >= 1
    vl(8'h22, 0, 1, 0),
    vl(8'h33, 0, 1, 0),
    vl(8'h7E, 1, 1, 1)
  };

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive on falling edge, release on next falling edge; sample afterwards
  task automatic cyc(input logic we, input logic [2:0] a, input logic [7:0] d,
                     input logic ld, input logic ce);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; ld_req = ld; cts_event = ce;
    @(negedge clk);
    wr_en = 1'b0; ld_req = 1'b0; cts_event = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic ld();
    cyc(1'b0, 3'd0, 8'h00, 1'b1, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ld_data", ld_data, 8'hFF);
    check("R1 ld_underflow", ld_underflow, 0);
    check("R1 sts_avail masked", sts_avail, 0);
    check("R1 sts_underflow", sts_underflow, 0);
    check("R1 sts_cts", sts_cts, 0);

    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = VEC[i];
      if (v[22]) ld(); else wr(v[21:19], v[18:11]);
      if (v[22]) begin
        check($sformatf("R2/R6/R7 vec%0d ld_data", i), ld_data, v[10:3]);
        check($sformatf("R6 vec%0d ld_underflow", i), ld_underflow, v[2]);
      end
      check($sformatf("R3/R4 vec%0d sts_avail", i), sts_avail, v[1]);
      check($sformatf("R6/R10 vec%0d sts_underflow", i), sts_underflow, v[0]);
    end
    // state: empty, trigger 1, sync fill on, underflow set
    @(negedge clk);
    check("R6 pulse one cycle", ld_underflow, 0);
    check("R12 ld_data holds", ld_data, 8'h7E);

    // R11 push and pop in one cycle with one entry queued
    wr(3'd4, 8'h44);
    cyc(1'b1, 3'd4, 8'h55, 1'b1, 1'b0);
    check("R11 pop returns old head", ld_data, 8'h44);
    check("R11 ld_underflow", ld_underflow, 0);
    check("R11 sts_avail", sts_avail, 1);
    ld();
    check("R11 pushed entry follows", ld_data, 8'h55);

    // R11 push on empty queue with underflow load
    cyc(1'b1, 3'd4, 8'h66, 1'b1, 1'b0);
    check("R11 empty collision sync", ld_data, 8'h7E);
    check("R11 empty collision pulse", ld_underflow, 1);
    ld();
    check("R11 written entry kept", ld_data, 8'h66);

    // R10 clear of underflow collides with an underflow load
    cyc(1'b1, 3'd2, 8'h01, 1'b1, 1'b0);
    check("R10 set wins tuf", sts_underflow, 1);
    check("R6 pulse on collision", ld_underflow, 1);

    // R10 cts set and clear
    cyc(1'b0, 3'd0, 8'h00, 1'b0, 1'b1);
    check("R10 cts set", sts_cts, 1);
    wr(3'd2, 8'h02);
    check("R10 cts cleared", sts_cts, 0);
    cyc(1'b1, 3'd2, 8'h02, 1'b0, 1'b1);
    check("R10 cts set wins", sts_cts, 1);

    // R8 / R9 / R5 transmitter reset
    wr(3'd0, 8'h01);
    check("R9 avail masked in reset", sts_avail, 0);
    check("R8 tuf cleared", sts_underflow, 0);
    check("R8 cts cleared", sts_cts, 0);
    wr(3'd4, 8'h5A);
    ld();
    check("R5 fill in reset", ld_data, 8'hFF);
    check("R5 no pulse in reset", ld_underflow, 0);
    wr(3'd0, 8'h00);
    check("R9 avail after release", sts_avail, 1);
    ld();
    check("R5 no pop in reset", ld_data, 8'h5A);

    // R8 discard on repeated reset, R7 fill with sync off
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h01);
    wr(3'd4, 8'h61);
    wr(3'd4, 8'h62);
    wr(3'd0, 8'h01);
    wr(3'd0, 8'h00);
    check("R8 flag set by reset", sts_avail, 1);
    ld();
    check("R8 contents discarded", ld_data, 8'hFF);
    check("R7 no pulse", ld_underflow, 0);
    check("R7 tuf unchanged", sts_underflow, 0);

    // R9 internal flag keeps tracking while masked
    wr(3'd0, 8'h01);
    wr(3'd4, 8'h71);
    wr(3'd4, 8'h72);
    wr(3'd4, 8'h73);
    wr(3'd0, 8'h00);
    check("R9 tracked flag low", sts_avail, 0);
    ld();
    check("R4 first pop", ld_data, 8'h71);
    check("R4 free 1 below trigger", sts_avail, 0);
    ld();
    check("R4 free 2 at trigger", sts_avail, 1);

    finish_run();
  end

endmodule